// File: doc/BRIEF.md
# PHY PLL Divider Search and Register Programming Sequencer

This block works out the feedback multiplier and input divider for a display link PHY PLL from two whole-MHz numbers: the reference clock frequency and the desired lane bit rate. The divided reference frequency must stay between 5 MHz and 40 MHz. Within that window, the block steps the input divider N upward. For each N it computes the integer multiplier M and accepts the first N whose M is even. It then picks a frequency-band code from a small, parameterised table of bit-rate bands. Finally it programs the PHY with five register writes in a fixed order, each handed to an external register writer and acknowledged before the next.

All arithmetic uses a single shift-subtract divider that the controller reuses. A one-cycle `start` launches a run. A one-cycle `done` ends it, with `err` set when no usable divider pair exists. After `done`, the outputs `n_out`, `m_out` and `lane_mhz` hold the chosen values and the lane rate actually achieved.

Top module: `pll_cfg_seq`

## Requirements
- R1: The divider search starts at N = max(1, floor(ref/40)) and gives up once N exceeds floor(ref/5); the N reported on a successful run lies inside that window.
- R2: For each candidate N the multiplier is M = floor(rate*N/ref); the first N (in increasing order) with an even M is chosen and reported on `n_out`/`m_out`.
- R3: If the window is empty, if no N in it gives an even M, or if the chosen M is zero, `done` comes with `err`=1, `n_out`, `m_out` and `lane_mhz` read 0, and no register write is issued.
- R4: The band code is taken from the lowest-indexed table entry whose inclusive low/high bounds contain the rate; it is 0 when no entry matches. The default table maps 80–89→0x00, 90–99→0x10, 100–109→0x20, 110–129→0x01, 130–139→0x11, 140–149→0x21, 150–169→0x02 and 160–1500→0x0A.
- R5: A successful run issues exactly five writes in this order. Address 0x44 receives the band code shifted left by one bit. Address 0x19 receives 0x30. Address 0x17 receives N−1. Address 0x18 receives (M−1) & 0x1F. Address 0x18 then receives 0x80 | (((M−1) >> 5) & 0x0F).
- R6: `wr_req` stays high with `wr_addr` and `wr_data` unchanged until `wr_ack` is seen, and a write is consumed only on the cycle `wr_ack` is high.
- R7: On success, `lane_mhz` = floor(ref*M/N).
- R8: `busy` is high from the cycle after an accepted `start` until `done`. `done` lasts one cycle. A `start` seen while busy is ignored and does not change the result.
- R9: After reset, `busy`, `done`, `err` and `wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch request, sampled when idle |
| ref_mhz | input | FW | Reference frequency in MHz |
| rate_mhz | input | FW | Target lane bit rate in Mbps |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No valid divider pair; valid with and after `done` |
| n_out | output | FW | Chosen input divider N |
| m_out | output | MW | Chosen multiplier M |
| lane_mhz | output | FW | Achieved lane rate ref*M/N |
| wr_req | output | 1 | Register write pending |
| wr_addr | output | 8 | PHY register address |
| wr_data | output | 8 | PHY register value |
| wr_ack | input | 1 | Writer accepts the pending write |

## Verification
The handshake assertions assume that `wr_ack` is raised only while `wr_req` is high. They also assume that `ref_mhz` and `rate_mhz` are stable on the cycle `start` is accepted. The window assertion assumes the reference stays at or below a few thousand MHz, so that N and M fit their widths. The bench's register writer acknowledges only pending requests, after delays of zero to two cycles. It holds the frequency inputs steady around each launch, except in the one test that deliberately changes them mid-run to show they are latched. All stimulus frequencies stay below 1600 MHz.

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq #(
  parameter int FW = 12,
  parameter int MW = 16,
  parameter int NR = 8,
  parameter int CW = 7,
  parameter logic [NR*FW-1:0] RNG_LO = {12'd160, 12'd150, 12'd140, 12'd130,
                                        12'd110, 12'd100, 12'd90,  12'd80},
  parameter logic [NR*FW-1:0] RNG_HI = {12'd1500, 12'd169, 12'd149, 12'd139,
                                        12'd129,  12'd109, 12'd99,  12'd89},
  parameter logic [NR*CW-1:0] RNG_CODE = {7'h0A, 7'h02, 7'h21, 7'h11,
                                          7'h01, 7'h20, 7'h10, 7'h00}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] ref_mhz,
  input  logic [FW-1:0] rate_mhz,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [FW-1:0] n_out,
  output logic [MW-1:0] m_out,
  output logic [FW-1:0] lane_mhz,
  output logic          wr_req,
  output logic [7:0]    wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_ack
);

  localparam int DW = 32;
  localparam int CNTW = $clog2(DW + 1);
  localparam logic [7:0] A_BAND = 8'h44;
  localparam logic [7:0] A_CTRL = 8'h19;
  localparam logic [7:0] A_NDIV = 8'h17;
  localparam logic [7:0] A_MDIV = 8'h18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_TRY, ST_MDIV, ST_RATE, ST_WR
  } st_t;

  st_t             st;
  logic [FW-1:0]   ref_q, rate_q, n_q, nmax_q, lane_q;
  logic [MW-1:0]   m_q;
  logic [CW-1:0]   code_q, code_hit;
  logic [2:0]      widx;
  logic            err_q, done_q;

  logic [DW-1:0]   quo_q;
  logic [FW-1:0]   rem_q, dsr_q;
  logic [CNTW-1:0] dcnt_q;
  logic [FW:0]     trial;
  logic [FW-1:0]   tdiff;
  logic            ge;

  assign trial = {rem_q, quo_q[DW-1]};
  assign ge    = trial >= {1'b0, dsr_q};
  assign tdiff = trial[FW-1:0] - dsr_q;

  always_comb begin
    code_hit = '0;
    for (int i = NR - 1; i >= 0; i--)
      if (rate_q >= RNG_LO[i*FW +: FW] && rate_q <= RNG_HI[i*FW +: FW])
        code_hit = RNG_CODE[i*CW +: CW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ref_q <= '0; rate_q <= '0; n_q <= '0; nmax_q <= '0; lane_q <= '0;
      m_q <= '0; code_q <= '0; widx <= '0; err_q <= 1'b0; done_q <= 1'b0;
      quo_q <= '0; rem_q <= '0; dsr_q <= '0; dcnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (dcnt_q != '0) begin
        rem_q  <= ge ? tdiff : trial[FW-1:0];
        quo_q  <= {quo_q[DW-2:0], ge};
        dcnt_q <= dcnt_q - 1'b1;
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            ref_q  <= ref_mhz;
            rate_q <= rate_mhz;
            err_q  <= 1'b0;
            quo_q  <= DW'(ref_mhz);
            dsr_q  <= FW'(40);
            rem_q  <= '0;
            dcnt_q <= CNTW'(DW);
            st     <= ST_LO;
          end
          ST_LO: begin
            n_q    <= (quo_q == '0) ? FW'(1) : quo_q[FW-1:0];
            quo_q  <= DW'(ref_q);
            dsr_q  <= FW'(5);
            rem_q  <= '0;
            dcnt_q <= CNTW'(DW);
            st     <= ST_HI;
          end
          ST_HI: begin
            nmax_q <= quo_q[FW-1:0];
            st     <= ST_TRY;
          end
          ST_TRY: begin
            if (n_q > nmax_q) begin
              err_q <= 1'b1; done_q <= 1'b1;
              n_q <= '0; m_q <= '0; lane_q <= '0;
              st <= ST_IDLE;
            end else begin
              quo_q  <= DW'(rate_q) * DW'(n_q);
              dsr_q  <= ref_q;
              rem_q  <= '0;
              dcnt_q <= CNTW'(DW);
              st     <= ST_MDIV;
            end
          end
          ST_MDIV: begin
            if (quo_q[0]) begin
              n_q <= n_q + 1'b1;
              st  <= ST_TRY;
            end else if (quo_q == '0) begin
              err_q <= 1'b1; done_q <= 1'b1;
              n_q <= '0; m_q <= '0; lane_q <= '0;
              st <= ST_IDLE;
            end else begin
              m_q    <= quo_q[MW-1:0];
              quo_q  <= DW'(ref_q) * DW'(quo_q[MW-1:0]);
              dsr_q  <= n_q;
              rem_q  <= '0;
              dcnt_q <= CNTW'(DW);
              st     <= ST_RATE;
            end
          end
          ST_RATE: begin
            lane_q <= quo_q[FW-1:0];
            code_q <= code_hit;
            widx   <= '0;
            st     <= ST_WR;
          end
          ST_WR: if (wr_ack) begin
            if (widx == 3'd4) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              widx <= widx + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  logic [8:0] mm1;
  assign mm1 = m_q[8:0] - 9'd1;

  always_comb begin
    case (widx)
      3'd0:    begin wr_addr = A_BAND; wr_data = 8'({code_q, 1'b0}); end
      3'd1:    begin wr_addr = A_CTRL; wr_data = 8'h30; end
      3'd2:    begin wr_addr = A_NDIV; wr_data = n_q[7:0] - 8'd1; end
      3'd3:    begin wr_addr = A_MDIV; wr_data = {3'b000, mm1[4:0]}; end
      default: begin wr_addr = A_MDIV; wr_data = {4'b1000, mm1[8:5]}; end
    endcase
  end

  assign wr_req   = (st == ST_WR);
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign n_out    = n_q;
  assign m_out    = m_q;
  assign lane_mhz = lane_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  assert_band_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && wr_addr == A_BAND |=> wr_req && wr_addr == A_CTRL);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> !m_out[0] && m_out != '0 && n_out != '0);

  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (32'(n_out) * 32'd5) <= 32'(ref_q));

  assert_fail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> lane_mhz == '0 && n_out == '0 && m_out == '0);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_req);

endmodule

// File: tb/tb_pll_cfg_seq.sv
`timescale 1ns/1ps
module tb_pll_cfg_seq;
  localparam int FW = 12;
  localparam int MW = 16;
  localparam int NV = 14;
  // ref, rate, err, N, M, lane, band write value
  localparam int VEC [NV][7] = '{
    '{20, 1000, 0, 1,  50, 1000, 8'h14},
    '{20, 1010, 0, 1,  50, 1000, 8'h14},
    '{20, 1030, 0, 3, 154, 1026, 8'h14},
    '{40,   85, 0, 1,   2,   80, 8'h00},
    '{100, 165, 0, 3,   4,  133, 8'h04},
    '{27,   95, 0, 3,  10,   90, 8'h20},
    '{4,   100, 1, 0,   0,    0, 0},
    '{40,   10, 1, 0,   0,    0, 0},
    '{5,     5, 1, 0,   0,    0, 0},
    '{10,   50, 0, 2,  10,   50, 8'h00},
    '{50, 1500, 0, 1,  30, 1500, 8'h14},
    '{90,   90, 0, 2,   2,   90, 8'h20},
    '{5,  1500, 0, 1, 300, 1500, 8'h14},
    '{89,   89, 0, 2,   2,   89, 8'h00}
  };

  logic clk = 0, rst_n = 0, start = 0, wr_ack = 0;
  logic [FW-1:0] ref_mhz = '0, rate_mhz = '0;
  logic busy, done, err, wr_req;
  logic [FW-1:0] n_out, lane_mhz;
  logic [MW-1:0] m_out;
  logic [7:0] wr_addr, wr_data;

  int compared = 0, mismatched = 0, ack_dly = 0, wcnt = 0;
  logic [7:0] wa [8];
  logic [7:0] wd [8];
  bit finished = 0;

  always #2 clk = ~clk;

  pll_cfg_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_mhz(ref_mhz), .rate_mhz(rate_mhz),
    .busy(busy), .done(done), .err(err), .n_out(n_out), .m_out(m_out),
    .lane_mhz(lane_mhz), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      wr_ack = 0;
      if (wr_req) begin
        repeat (ack_dly) @(negedge clk);
        if (wcnt < 8) begin
          wa[wcnt] = wr_addr;
          wd[wcnt] = wr_data;
        end
        wcnt++;
        wr_ack = 1;
      end
    end
  end

  task automatic run(input int rf, input int rt, input bit poke);
    int cyc;
    @(negedge clk);
    wcnt = 0;
    ref_mhz = FW'(rf);
    rate_mhz = FW'(rt);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R8 busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 5) begin
        ref_mhz = FW'(40);
        rate_mhz = FW'(85);
        start = 1;
      end else if (poke && cyc == 6) begin
        start = 0;
      end
    end
    if (!done) chk("R8 done timeout", 0, 1);
  endtask

  task automatic check_result(input int k);
    int n, m;
    n = VEC[k][3];
    m = VEC[k][4];
    chk("R3 err flag", err, VEC[k][2]);
    chk("R1 R2 N", n_out, n);
    chk("R2 M", m_out, m);
    chk("R7 lane rate", lane_mhz, VEC[k][5]);
    chk("R8 busy low at done", busy, 0);
    if (VEC[k][2] != 0) begin
      chk("R3 no writes on error", wcnt, 0);
    end else begin
      chk("R5 write count", wcnt, 5);
      if (wcnt == 5) begin
        chk("R5 addr0", wa[0], 8'h44); chk("R4 R5 band value", wd[0], VEC[k][6]);
        chk("R5 addr1", wa[1], 8'h19); chk("R5 data1", wd[1], 8'h30);
        chk("R5 addr2", wa[2], 8'h17); chk("R5 N-1", wd[2], (n - 1) & 8'hFF);
        chk("R5 addr3", wa[3], 8'h18); chk("R5 M-1 low", wd[3], (m - 1) & 8'h1F);
        chk("R5 addr4", wa[4], 8'h18);
        chk("R5 M-1 high", wd[4], 8'h80 | (((m - 1) >> 5) & 8'h0F));
      end
    end
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
  endtask

  initial begin
    #400000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", busy, 0);
    chk("R9 wr_req in reset", wr_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 err", err, 0);
    chk("R9 wr_req", wr_req, 0);

    for (int k = 0; k < NV; k++) begin
      ack_dly = k % 3;
      run(VEC[k][0], VEC[k][1], 0);
      check_result(k);
    end

    // R8: a second start during a run is ignored; inputs are latched
    ack_dly = 1;
    run(VEC[2][0], VEC[2][1], 1);
    check_result(2);

    // R6: long acknowledge delay still yields the exact write sequence
    ack_dly = 2;
    run(VEC[12][0], VEC[12][1], 0);
    check_result(12);

    // R3 then success: error state does not linger
    ack_dly = 0;
    run(VEC[7][0], VEC[7][1], 0);
    check_result(7);
    run(VEC[4][0], VEC[4][1], 0);
    check_result(4);

    finish_run();
  end
endmodule